// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers interrupt requests from six external pins and presents at most one of them to a processor core. Every pin has its own control register with a three-bit priority level, a pending flag, a polarity choice and a choice between edge and level sensing. A shared register turns on dual-edge detection for individual pins. Each pin is brought into the clock domain through a two-stage synchronizer, and a qualifying event on it sets the pin's pending flag.

An arbiter picks the pending, enabled source with the highest level, and the lowest source number when levels tie. It offers that source to the core only if its level is strictly above the core's current priority level. The offer is made by a small state machine. In state ARB_IDLE it evaluates the winner each cycle. The transition ARB_IDLE to ARB_OFFER (take) happens when a winner beats the processor level; the source number is latched at that moment. The machine stays in ARB_OFFER (hold) until a vector-fetch acknowledge arrives. The transition ARB_OFFER to ARB_IDLE (release) then clears the offered source's pending flag.

Software reaches the control registers through a plain write/read port. Software can clear a pending flag but can never set one.

Top module: `eirc_top`

## Requirements
- R1: After reset, every control register and the dual-edge register read 0 and `irq_accept` is low.
- R2: Control register at address n (n = 0..5) holds the level in bits 2..0, the pending flag in bit 3, polarity in bit 4 and the sense select in bit 5. Address 6 holds the dual-edge enables in bits 5..0. Bits 7..6 always read 0 and writes to them are ignored. Address 7 reads 0.
- R3: In edge mode (sense bit 0, dual-edge 0), polarity 0 sets the pending flag on a falling pin transition and polarity 1 on a rising one. The flag reads 1 by the third rising clock edge after the pin change. The opposite transition has no effect.
- R4: With the pin's dual-edge enable at 1 and polarity 0, both rising and falling transitions set the pending flag.
- R5: In level mode (sense bit 1), the pending flag is set on every cycle in which the pin sits at its active level (low for polarity 0, high for polarity 1). It therefore reappears after a clear or an acknowledge while the pin stays active. The inactive level sets nothing.
- R6: Writing a control register with bit 3 at 0 clears that pending flag. Writing bit 3 at 1 leaves the flag unchanged. A pin event in the same cycle as a clear keeps the flag at 1.
- R7: A source with level 0 is never offered, even while its pending flag is 1.
- R8: A pending source is offered only when its level is strictly greater than `cpu_ipl`. Equal or lower levels are held off.
- R9: Among offerable sources the highest level wins; on equal levels the lowest source number wins.
- R10: `irq_accept` stays high with a constant `irq_src` until `vec_ack` is seen. That acknowledge clears the offered source's pending flag and drops `irq_accept` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 6 | Asynchronous external interrupt pins |
| cpu_ipl | input | 3 | Current processor priority level |
| vec_ack | input | 1 | Vector-fetch acknowledge pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0..5 control, 6 dual-edge) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_accept | output | 1 | Request offered to the core |
| irq_src | output | 3 | Number of the offered source |

## Verification
The assertions take for granted that `vec_ack` is raised only while `irq_accept` is high. They also assume that dual-edge enables are used only with polarity 0, and level sensing only with the dual-edge bit at 0. The stimulus keeps to these rules: each scenario restores its pins to the high, inactive state and clears the configuration before the next one starts. Pins change only at falling clock edges, so synchronizer latency can be counted exactly. The processor level is held at 7 whenever a scenario sets up pending flags that are not meant to be offered yet.

// File: rtl/eirc_pkg.sv
package eirc_pkg;

    localparam int LVL_W     = 3;
    localparam int LVL_LSB   = 0;
    localparam int PEND_BIT  = 3;
    localparam int POL_BIT   = 4;
    localparam int SENSE_BIT = 5;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_OFFER = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic             sense;
        logic             pol;
        logic [LVL_W-1:0] lvl;
    } src_cfg_t;

endpackage

// File: rtl/eirc_pin.sv
module eirc_pin #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol,
    input  logic sense,
    input  logic both,
    input  logic sw_clr,
    input  logic ack_clr,
    output logic pend,
    output logic evt
);

    logic [SYNC_N-1:0] sh;
    logic              synced;
    logic              prev;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[SYNC_N-2:0], pin};
            prev <= synced;
        end
    end

    assign synced = sh[SYNC_N-1];
    assign rise   = synced & ~prev;
    assign fall   = ~synced & prev;

    always_comb begin
        if (sense) begin
            evt = pol ? synced : ~synced;
        end else if (both) begin
            evt = rise | fall;
        end else begin
            evt = pol ? rise : fall;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (evt) begin
            pend <= 1'b1;
        end else if (sw_clr || ack_clr) begin
            pend <= 1'b0;
        end
    end

    AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend); // R3
    AST_SW_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !pend) |=> !pend); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && !evt) |=> !pend); // R10

endmodule

// File: rtl/eirc_regs.sv
module eirc_regs
    import eirc_pkg::*;
#(
    parameter int NSRC   = 6,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NSRC-1:0]      pend,
    output src_cfg_t [NSRC-1:0]  cfg,
    output logic [NSRC-1:0]      both,
    output logic [NSRC-1:0]      sw_clr,
    output logic [DATA_W-1:0]    rdata
);

    localparam logic [ADDR_W-1:0] BOTH_ADDR = ADDR_W'(NSRC);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg  <= '0;
            both <= '0;
        end else if (we) begin
            for (int i = 0; i < NSRC; i++) begin
                if (addr == ADDR_W'(i)) begin
                    cfg[i].lvl   <= wdata[LVL_LSB +: LVL_W];
                    cfg[i].pol   <= wdata[POL_BIT];
                    cfg[i].sense <= wdata[SENSE_BIT];
                end
            end
            if (addr == BOTH_ADDR) begin
                both <= wdata[NSRC-1:0];
            end
        end
    end

    always_comb begin
        sw_clr = '0;
        for (int i = 0; i < NSRC; i++) begin
            sw_clr[i] = we && (addr == ADDR_W'(i)) && !wdata[PEND_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata[LVL_LSB +: LVL_W] = cfg[i].lvl;
                rdata[PEND_BIT]         = pend[i];
                rdata[POL_BIT]          = cfg[i].pol;
                rdata[SENSE_BIT]        = cfg[i].sense;
            end
        end
        if (addr == BOTH_ADDR) begin
            rdata = DATA_W'(both);
        end
    end

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1 -: 2] == 2'b00); // R2
    AST_RSVD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (|wdata[DATA_W-1 -: 2])) |=> (rdata[DATA_W-1 -: 2] == 2'b00)); // R2
    AST_CLR_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_clr)); // R6

endmodule

// File: rtl/eirc_arb.sv
module eirc_arb
    import eirc_pkg::*;
#(
    parameter int NSRC  = 6,
    parameter int IDX_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             pend,
    input  logic [NSRC-1:0][LVL_W-1:0]  lvl,
    input  logic [LVL_W-1:0]            ipl,
    input  logic                        ack,
    output logic                        accept,
    output logic [IDX_W-1:0]            idx,
    output logic [NSRC-1:0]             clr
);

    arb_state_e       state;
    arb_state_e       state_nxt;
    logic [LVL_W-1:0] best_lvl;
    logic [IDX_W-1:0] best_idx;
    logic             found;
    logic             win_ok;
    logic [NSRC-1:0]  above;
    logic             above_any;
    logic [IDX_W-1:0] idx_q;

    // winner: strict compare while scanning upward keeps the lowest index on ties
    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        found    = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && (lvl[i] != '0) && (lvl[i] > best_lvl)) begin
                best_lvl = lvl[i];
                best_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
        win_ok = found && (best_lvl > ipl);
    end

    // independent per-source eligibility, used by the checks
    for (genvar g = 0; g < NSRC; g++) begin : g_above
        assign above[g] = pend[g] && (lvl[g] != '0) && (lvl[g] > ipl);
    end
    assign above_any = |above;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ARB_IDLE:  if (win_ok) state_nxt = ARB_OFFER;
            ARB_OFFER: if (ack)    state_nxt = ARB_IDLE;
            default:               state_nxt = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (state == ARB_IDLE && win_ok) begin
            idx_q <= best_idx;
        end
    end

    always_comb begin
        accept = (state == ARB_OFFER);
        idx    = idx_q;
        clr    = '0;
        if (state == ARB_OFFER && ack) begin
            clr[idx_q] = 1'b1;
        end
    end

    AST_NO_ACCEPT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE && !above_any) |=> !accept); // R8
    AST_ACCEPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !ack) |=> (accept && $stable(idx))); // R10
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (idx < IDX_W'(NSRC))); // R10

endmodule

// File: rtl/eirc_top.sv
module eirc_top
    import eirc_pkg::*;
#(
    parameter int NSRC   = 6,
    parameter int SYNC_N = 2,
    parameter int DATA_W = 8,
    localparam int IDX_W  = $clog2(NSRC),
    localparam int ADDR_W = $clog2(NSRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   ext_pin,
    input  logic [LVL_W-1:0]  cpu_ipl,
    input  logic              vec_ack,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_accept,
    output logic [IDX_W-1:0]  irq_src
);

    src_cfg_t [NSRC-1:0]             cfg;
    logic [NSRC-1:0]                 both;
    logic [NSRC-1:0]                 sw_clr;
    logic [NSRC-1:0]                 ack_clr;
    logic [NSRC-1:0]                 pend;
    logic [NSRC-1:0]                 evt;
    logic [NSRC-1:0][LVL_W-1:0]      lvl;

    eirc_regs #(
        .NSRC   (NSRC),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .pend   (pend),
        .cfg    (cfg),
        .both   (both),
        .sw_clr (sw_clr),
        .rdata  (reg_rdata)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign lvl[g] = cfg[g].lvl;

        eirc_pin #(
            .SYNC_N (SYNC_N)
        ) u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (ext_pin[g]),
            .pol     (cfg[g].pol),
            .sense   (cfg[g].sense),
            .both    (both[g]),
            .sw_clr  (sw_clr[g]),
            .ack_clr (ack_clr[g]),
            .pend    (pend[g]),
            .evt     (evt[g])
        );
    end

    eirc_arb #(
        .NSRC  (NSRC),
        .IDX_W (IDX_W)
    ) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend),
        .lvl    (lvl),
        .ipl    (cpu_ipl),
        .ack    (vec_ack),
        .accept (irq_accept),
        .idx    (irq_src),
        .clr    (ack_clr)
    );

    AST_ACK_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_clr)); // R10
    AST_ACK_DROPS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && vec_ack) |=> !irq_accept); // R10

endmodule

// File: tb/tb_eirc_top.sv
module tb_eirc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] pins = 6'h3F;
    logic [2:0] ipl = 3'd7;
    logic       ack = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       accept;
    logic [2:0] src;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    eirc_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_pin    (pins),
        .cpu_ipl    (ipl),
        .vec_ack    (ack),
        .reg_we     (we),
        .reg_addr   (addr),
        .reg_wdata  (wdata),
        .reg_rdata  (rdata),
        .irq_accept (accept),
        .irq_src    (src)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        we = 1'b1; addr = 3'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        addr = 3'(a);
        #1;
        d = rdata;
    endtask

    task automatic pend_of(input int a, output int p);
        logic [7:0] d;
        rd(a, d);
        p = int'(d[3]);
    endtask

    task automatic wait_accept(input int maxc, output bit got);
        got = 1'b0;
        for (int k = 0; k < maxc; k++) begin
            if (accept) begin
                got = 1'b1;
                break;
            end
            step(1);
        end
    endtask

    task automatic do_ack();
        ack = 1'b1;
        step(1);
        ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(a, d);
            chk("R1 reg reset", int'(d), 0);
        end
        chk("R1 accept reset", int'(accept), 0);
    endtask

    task automatic t_layout();
        logic [7:0] d;
        wr(0, 8'hCF);
        rd(0, d);
        chk("R2 lvl field, rsvd ignored, pend not set", int'(d), 8'h07);
        wr(5, 8'hD3);
        rd(5, d);
        chk("R2 pol and lvl fields", int'(d), 8'h13);
        wr(6, 8'hFF);
        rd(6, d);
        chk("R2 dual-edge reg", int'(d), 8'h3F);
        rd(7, d);
        chk("R2 addr 7 zero", int'(d), 0);
        wr(6, 8'h00); wr(0, 8'h00); wr(5, 8'h00);
    endtask

    task automatic t_edge();
        int p;
        wr(1, 8'h00);
        pins[1] = 1'b0; step(3);
        pend_of(1, p); chk("R3 falling sets pol0", p, 1);
        wr(1, 8'h00);
        pend_of(1, p); chk("R6 write 0 clears", p, 0);
        wr(1, 8'h10);
        pins[1] = 1'b1; step(3);
        pend_of(1, p); chk("R3 rising sets pol1", p, 1);
        wr(1, 8'h10);
        pins[1] = 1'b0; step(5);
        pend_of(1, p); chk("R3 falling ignored pol1", p, 0);
        wr(1, 8'h00);
        pins[1] = 1'b1; step(5);
        pend_of(1, p); chk("R3 rising ignored pol0", p, 0);
    endtask

    task automatic t_both();
        int p;
        wr(2, 8'h00); wr(6, 8'h04);
        pins[2] = 1'b0; step(3);
        pend_of(2, p); chk("R4 dual-edge falling", p, 1);
        wr(2, 8'h00);
        pins[2] = 1'b1; step(3);
        pend_of(2, p); chk("R4 dual-edge rising", p, 1);
        wr(2, 8'h00); wr(6, 8'h00);
    endtask

    task automatic t_level();
        int p;
        bit got;
        wr(3, 8'h23);
        step(4);
        pend_of(3, p); chk("R5 inactive level no set", p, 0);
        pins[3] = 1'b0; step(3);
        pend_of(3, p); chk("R5 active low sets", p, 1);
        ipl = 3'd0;
        wait_accept(10, got);
        chk("R5 level source offered", int'(got), 1);
        chk("R5 level source index", int'(src), 3);
        ipl = 3'd7;
        do_ack();
        pend_of(3, p); chk("R5 reasserts after ack", p, 1);
        pins[3] = 1'b1; step(3);
        wr(3, 8'h00);
        pend_of(3, p); chk("R5 cleared after release", p, 0);
    endtask

    task automatic t_sw();
        int p;
        logic [7:0] d;
        wr(4, 8'h00);
        pins[4] = 1'b0; step(3);
        wr(4, 8'h08);
        rd(4, d); chk("R6 write 1 keeps flag", int'(d), 8'h08);
        wr(4, 8'h00);
        pend_of(4, p); chk("R6 clear", p, 0);
        pins[4] = 1'b1; step(3);
        wr(4, 8'h08);
        pend_of(4, p); chk("R6 write 1 cannot set", p, 0);
        wr(4, 8'h20);
        pins[4] = 1'b0; step(3);
        wr(4, 8'h20);
        pend_of(4, p); chk("R6 event beats clear", p, 1);
        pins[4] = 1'b1; step(3);
        wr(4, 8'h00);
    endtask

    task automatic t_disable();
        int p;
        int seen = 0;
        wr(0, 8'h00);
        pins[0] = 1'b0; step(3);
        pend_of(0, p); chk("R7 pending held at level 0", p, 1);
        ipl = 3'd0;
        for (int k = 0; k < 10; k++) begin
            step(1);
            if (accept) seen++;
        end
        chk("R7 level 0 never offered", seen, 0);
        ipl = 3'd7;
        pins[0] = 1'b1; step(3);
        wr(0, 8'h00);
    endtask

    task automatic t_ipl();
        int p;
        int seen = 0;
        bit got;
        wr(1, 8'h04);
        pins[1] = 1'b0; step(3);
        ipl = 3'd4;
        for (int k = 0; k < 8; k++) begin
            step(1);
            if (accept) seen++;
        end
        chk("R8 equal level held off", seen, 0);
        ipl = 3'd3;
        wait_accept(10, got);
        chk("R8 higher level offered", int'(got), 1);
        chk("R8 offered index", int'(src), 1);
        ipl = 3'd7;
        step(3);
        chk("R10 accept held without ack", int'(accept), 1);
        chk("R10 index stable", int'(src), 1);
        do_ack();
        chk("R10 accept drops after ack", int'(accept), 0);
        pend_of(1, p); chk("R10 ack clears pending", p, 0);
        pins[1] = 1'b1; step(3);
        wr(1, 8'h00);
    endtask

    task automatic t_prio();
        bit got;
        wr(0, 8'h03); wr(2, 8'h05); wr(5, 8'h05);
        pins[0] = 1'b0; pins[2] = 1'b0; pins[5] = 1'b0;
        step(4);
        ipl = 3'd0;
        wait_accept(10, got);
        chk("R9 tie lowest index first", int'(src), 2);
        do_ack();
        wait_accept(10, got);
        chk("R9 tied peer next", int'(src), 5);
        do_ack();
        wait_accept(10, got);
        chk("R9 lower level last", int'(src), 0);
        do_ack();
        step(4);
        chk("R10 nothing left after acks", int'(accept), 0);
        ipl = 3'd7;
        pins[0] = 1'b1; pins[2] = 1'b1; pins[5] = 1'b1;
        step(3);
        wr(0, 8'h00); wr(2, 8'h00); wr(5, 8'h00);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_layout();
        t_edge();
        t_both();
        t_level();
        t_sw();
        t_disable();
        t_ipl();
        t_prio();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule